// File: doc/BRIEF.md
# Alarm Match Unit

This block sits beside the calendar counters of a real-time clock and decides when the alarm goes off. On every one-second tick it compares the current BCD time fields (second, minute, hour, day of month, month) with a stored alarm time. A five-bit repeat code chooses how many of those fields must agree, from none (an alarm every second) up to all five (an alarm once a year). A match sets a sticky alarm flag. The flag stays set until software reads the flag register.

The block drives one open-drain pin. When the interrupt enable bit is set, the pin is pulled low while the flag is set. When the enable is clear, the pin acts as a plain general-purpose output controlled by a separate output bit. The register pointer of the bus front end is an input. While that pointer rests on the flag register, a new match is held back as pending. The pending match reaches the flag only after the pointer moves away.

The enable bit and the output bit are held inside the block and are loaded through a simple write strobe. The time fields, the alarm fields, the repeat code, the pointer and the read strobe come from neighbouring logic.

Top module: `rtc_alarm_unit`

## Requirements
- R1: With repeat code 5'b11111 (rpt_code bit 4 down to bit 0), every tick is a match, whatever the time fields hold.
- R2: Each match is one step wider than the one before it. Code 5'b11110 compares seconds. 5'b11100 compares seconds and minutes. 5'b11000 compares seconds, minutes and hours. 5'b10000 adds the day of month. 5'b00000 adds the month. Fields are packed eight bits each in time vectors: second [7:0], minute [15:8], hour [23:16], day of month [31:24], month [39:32].
- R3: Any repeat code outside the six in R2 and R1 behaves as a match on every tick.
- R4: When the repeat code is 5'b00000 and the alarm day-of-month field is 8'h00, the alarm is off and no tick sets the flag.
- R5: A match is judged only in a cycle with tick high. The flag becomes 1 in the cycle after that tick and stays 1 across later non-matching ticks until it is cleared.
- R6: A flag_rd pulse clears the flag in the next cycle. With the interrupt enable set, the pin is released at the same time.
- R7: While ptr_addr equals the flag register address (4'hF), a match leaves the flag at 0 and is held as pending. The flag rises in the cycle after ptr_addr changes to any other value.
- R8: When a match (new, or a pending one being released) and a flag_rd pulse fall in the same cycle, the flag ends up set.
- R9: With the interrupt enable at 1, pin_pull_low follows the flag. With the enable at 0, pin_pull_low is 1 when the output bit is 0 and 0 when the output bit is 1.
- R10: After reset the flag is 0, the interrupt enable is 0, the output bit is 1, and pin_pull_low is 0.
- R11: A cfg_we pulse loads cfg_irq_en and cfg_out_bit. The pin reflects the new values from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse when a new second is valid in cur_time |
| cur_time | input | 40 | Current BCD time: month, day of month, hour, minute, second |
| alm_time | input | 40 | Alarm BCD time, same packing as cur_time |
| rpt_code | input | 5 | Repeat code, bit 4 is the widest-scope bit |
| ptr_addr | input | 4 | Current register pointer of the bus front end |
| flag_rd | input | 1 | Pulse when the flag register is read |
| cfg_we | input | 1 | Write strobe for the enable and output bits |
| cfg_irq_en | input | 1 | New value of the interrupt enable |
| cfg_out_bit | input | 1 | New value of the general-purpose output bit |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_pend | output | 1 | Match held back while the pointer is on the flag register |
| pin_pull_low | output | 1 | 1 pulls the open-drain pin low, 0 releases it |

## Verification
The flag has a set path and a clear path, and both can act in the same cycle. A read strobe can arrive together with a matching tick. A read strobe can also arrive in the same cycle that the pointer leaves the flag address while a match is pending. The bench drives both cases on the same negative edge and checks in the next cycle that the flag reads 1. It then checks that a lone read clears it. Suppression is judged the same way: the flag must stay low for several cycles while the pointer holds 4'hF, then rise exactly one cycle after the pointer moves.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
   // Field positions inside a packed time vector, least significant first.
   localparam int unsigned FLD_SEC   = 0;
   localparam int unsigned FLD_MIN   = 1;
   localparam int unsigned FLD_HOUR  = 2;
   localparam int unsigned FLD_DATE  = 3;
   localparam int unsigned FLD_MONTH = 4;

   // How the open-drain pin is produced from the flag and configuration state.
   typedef enum logic {
      PIN_COMB = 1'b0,
      PIN_REG  = 1'b1
   } pin_drive_e;
endpackage

// File: rtl/alarm_repeat_decode.sv
module alarm_repeat_decode #(
   parameter int unsigned RPT_W      = 5,
   parameter int unsigned NUM_FIELDS = 5
) (
   input  logic [RPT_W-1:0]      rpt_code,
   output logic [NUM_FIELDS-1:0] cmp_mask
);
   localparam int unsigned LVL_W = $clog2(RPT_W + 1);
   localparam logic [RPT_W-1:0] ONES = '1;

   logic [LVL_W-1:0] level;

   // A valid code is all ones with k trailing zeros; k fields take part.
   // Anything else leaves the level at zero: match on every tick.
   always_comb begin
      level = '0;
      for (int k = 1; k <= int'(RPT_W); k++) begin
         if (rpt_code == (ONES << k)) level = LVL_W'(k);
      end
   end

   for (genvar i = 0; i < int'(NUM_FIELDS); i++) begin : g_mask
      assign cmp_mask[i] = (level > LVL_W'(i));
   end
endmodule

// File: rtl/alarm_field_compare.sv
module alarm_field_compare #(
   parameter int unsigned FIELD_W    = 8,
   parameter int unsigned NUM_FIELDS = 5
) (
   input  logic [NUM_FIELDS*FIELD_W-1:0] cur_time,
   input  logic [NUM_FIELDS*FIELD_W-1:0] alm_time,
   input  logic [NUM_FIELDS-1:0]         cmp_mask,
   output logic                          all_match
);
   logic [NUM_FIELDS-1:0] fld_ok;

   for (genvar i = 0; i < int'(NUM_FIELDS); i++) begin : g_fld
      assign fld_ok[i] = !cmp_mask[i] ||
                         (cur_time[i*FIELD_W +: FIELD_W] == alm_time[i*FIELD_W +: FIELD_W]);
   end

   assign all_match = &fld_ok;
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic match_evt,
   input  logic on_flag_reg,
   input  logic flag_rd,
   output logic flag_q,
   output logic pend_q
);
   logic raise;

   assign raise = (match_evt || pend_q) && !on_flag_reg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= on_flag_reg && (pend_q || match_evt);
         if (raise)        flag_q <= 1'b1;
         else if (flag_rd) flag_q <= 1'b0;
      end
   end

   // R7: no new flag while the pointer sits on the flag register
   assert_hold_on_flag_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (on_flag_reg && !flag_q) |=> !flag_q);

   // R7: a held match is released once the pointer moves on
   assert_pend_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !on_flag_reg) |=> (flag_q && !pend_q));

   // R6: a read with no competing set clears the flag
   assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rd && on_flag_reg) |=> !flag_q);

   // R8: a set in the same cycle as a read wins
   assert_set_beats_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rd && match_evt && !on_flag_reg) |=> flag_q);

   // R5: the flag only rises after a match or a release
   assert_rise_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(match_evt || pend_q));
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned FIELD_W    = 8,
   parameter int unsigned NUM_FIELDS = 5,
   parameter int unsigned RPT_W      = 5,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned FLAG_ADDR  = 15,
   parameter pin_drive_e  PIN_DRIVE  = PIN_COMB
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick,
   input  logic [NUM_FIELDS*FIELD_W-1:0] cur_time,
   input  logic [NUM_FIELDS*FIELD_W-1:0] alm_time,
   input  logic [RPT_W-1:0]              rpt_code,
   input  logic [ADDR_W-1:0]             ptr_addr,
   input  logic                          flag_rd,
   input  logic                          cfg_we,
   input  logic                          cfg_irq_en,
   input  logic                          cfg_out_bit,
   output logic                          alarm_flag,
   output logic                          alarm_pend,
   output logic                          pin_pull_low
);
   localparam int unsigned TIME_W = NUM_FIELDS * FIELD_W;
   localparam logic [ADDR_W-1:0] FLAG_PTR = ADDR_W'(FLAG_ADDR);
   localparam logic [RPT_W-1:0]  RPT_EVERY = '1;

   if (RPT_W != NUM_FIELDS) begin : g_bad_rpt
      $error("rtc_alarm_unit: RPT_W must equal NUM_FIELDS");
   end
   if (NUM_FIELDS <= FLD_DATE) begin : g_bad_fields
      $error("rtc_alarm_unit: the day-of-month field must exist");
   end
   if (FLAG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("rtc_alarm_unit: FLAG_ADDR does not fit ADDR_W");
   end

   logic                  irq_en_q;
   logic                  out_bit_q;
   logic [NUM_FIELDS-1:0] cmp_mask;
   logic                  all_match;
   logic                  alarm_off;
   logic                  on_flag_reg;
   logic                  match_evt;
   logic                  pull_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_en_q  <= 1'b0;
         out_bit_q <= 1'b1;
      end else if (cfg_we) begin
         irq_en_q  <= cfg_irq_en;
         out_bit_q <= cfg_out_bit;
      end
   end

   alarm_repeat_decode #(
      .RPT_W      (RPT_W),
      .NUM_FIELDS (NUM_FIELDS)
   ) u_decode (
      .rpt_code (rpt_code),
      .cmp_mask (cmp_mask)
   );

   alarm_field_compare #(
      .FIELD_W    (FIELD_W),
      .NUM_FIELDS (NUM_FIELDS)
   ) u_compare (
      .cur_time  (cur_time),
      .alm_time  (alm_time),
      .cmp_mask  (cmp_mask),
      .all_match (all_match)
   );

   assign alarm_off   = (rpt_code == '0) &&
                        (alm_time[FLD_DATE*FIELD_W +: FIELD_W] == '0);
   assign on_flag_reg = (ptr_addr == FLAG_PTR);
   assign match_evt   = tick && all_match && !alarm_off;

   alarm_flag_ctrl u_flag (
      .clk         (clk),
      .rst_n       (rst_n),
      .match_evt   (match_evt),
      .on_flag_reg (on_flag_reg),
      .flag_rd     (flag_rd),
      .flag_q      (alarm_flag),
      .pend_q      (alarm_pend)
   );

   assign pull_next = irq_en_q ? alarm_flag : !out_bit_q;

   if (PIN_DRIVE == PIN_REG) begin : g_pin_reg
      logic pull_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pull_q <= 1'b0;
         else        pull_q <= pull_next;
      end
      assign pin_pull_low = pull_q;
   end else begin : g_pin_comb
      assign pin_pull_low = pull_next;

      // R9: with the enable set the pin tracks the flag
      assert_pin_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
         irq_en_q |-> (pin_pull_low == alarm_flag));
   end

   // R4: a disabled alarm never produces a match
   assert_off_is_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && alarm_off && !alarm_pend && !alarm_flag) |=> !alarm_flag);

   // R1: the every-second code raises the flag on each tick
   assert_every_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && rpt_code == RPT_EVERY && !on_flag_reg) |=> alarm_flag);

   // R5: with no tick and nothing pending the flag cannot rise
   assert_tick_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !alarm_pend && !alarm_flag) |=> !alarm_flag);

   // R11: configuration lands one cycle after the strobe
   assert_cfg_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (irq_en_q == $past(cfg_irq_en) && out_bit_q == $past(cfg_out_bit)));
endmodule

// File: tb/rtc_alarm_unit_tb.sv
module rtc_alarm_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [39:0] cur_time = '0;
   logic [39:0] alm_time = '0;
   logic [4:0]  rpt_code = '0;
   logic [3:0]  ptr_addr = '0;
   logic        flag_rd = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_irq_en = 1'b0;
   logic        cfg_out_bit = 1'b1;
   logic        alarm_flag;
   logic        alarm_pend;
   logic        pin_pull_low;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rtc_alarm_unit u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .cur_time     (cur_time),
      .alm_time     (alm_time),
      .rpt_code     (rpt_code),
      .ptr_addr     (ptr_addr),
      .flag_rd      (flag_rd),
      .cfg_we       (cfg_we),
      .cfg_irq_en   (cfg_irq_en),
      .cfg_out_bit  (cfg_out_bit),
      .alarm_flag   (alarm_flag),
      .alarm_pend   (alarm_pend),
      .pin_pull_low (pin_pull_low)
   );

   // Alarm at month 06, date 15, 23:45:30. Vector: {rpt, cur, alm, expected}.
   localparam logic [39:0] ALM = 40'h06_15_23_45_30;
   localparam logic [85:0] VEC [14] = '{
      {5'b11111, 40'h01_01_00_00_00, ALM, 1'b1},               // R1
      {5'b11110, 40'h01_01_00_00_30, ALM, 1'b1},               // R2 seconds
      {5'b11110, 40'h06_15_23_45_31, ALM, 1'b0},               // R2
      {5'b11100, 40'h01_01_00_45_30, ALM, 1'b1},               // R2 minutes
      {5'b11100, 40'h06_15_23_44_30, ALM, 1'b0},               // R2
      {5'b11000, 40'h01_01_23_45_30, ALM, 1'b1},               // R2 hours
      {5'b11000, 40'h06_15_22_45_30, ALM, 1'b0},               // R2
      {5'b10000, 40'h01_15_23_45_30, ALM, 1'b1},               // R2 date
      {5'b10000, 40'h06_14_23_45_30, ALM, 1'b0},               // R2
      {5'b00000, 40'h06_15_23_45_30, ALM, 1'b1},               // R2 month
      {5'b00000, 40'h07_15_23_45_30, ALM, 1'b0},               // R2
      {5'b01010, 40'h01_01_00_00_00, ALM, 1'b1},               // R3
      {5'b11101, 40'h09_09_09_09_09, ALM, 1'b1},               // R3
      {5'b00000, 40'h06_00_23_45_30, 40'h06_00_23_45_30, 1'b0} // R4
   };

   task automatic check(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic clear_flag();
      ptr_addr = 4'h0;
      flag_rd  = 1'b1;
      step();
      flag_rd  = 1'b0;
   endtask

   task automatic set_cfg(input logic en, input logic ob);
      cfg_we = 1'b1; cfg_irq_en = en; cfg_out_bit = ob;
      step();
      cfg_we = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      // R10: reset state
      check(alarm_flag, 1'b0, "R10 flag");
      check(pin_pull_low, 1'b0, "R10 pin");
      rst_n = 1'b1;
      step();
      check(pin_pull_low, 1'b0, "R10 pin after reset");

      // Vector table: R1 R2 R3 R4
      for (int i = 0; i < 14; i++) begin
         rpt_code = VEC[i][85:81];
         cur_time = VEC[i][80:41];
         alm_time = VEC[i][40:1];
         tick = 1'b1;
         step();
         tick = 1'b0;
         check(alarm_flag, VEC[i][0], $sformatf("R1/R2/R3/R4 vector %0d", i));
         clear_flag();
      end

      // R5: matching fields without a tick do nothing
      rpt_code = 5'b11111; alm_time = ALM; cur_time = ALM;
      repeat (3) step();
      check(alarm_flag, 1'b0, "R5 no tick");
      // R5: sticky across non-matching ticks
      tick = 1'b1; step(); tick = 1'b0;
      check(alarm_flag, 1'b1, "R5 set after tick");
      rpt_code = 5'b00000; cur_time = 40'h01_01_00_00_00;
      tick = 1'b1; step(); step(); tick = 1'b0; step();
      check(alarm_flag, 1'b1, "R5 sticky");

      // R11 R9: enable clear, pin follows output bit
      set_cfg(1'b0, 1'b0);
      check(pin_pull_low, 1'b1, "R11 R9 out bit 0 pulls low");
      set_cfg(1'b0, 1'b1);
      check(pin_pull_low, 1'b0, "R11 R9 out bit 1 releases");
      // R9: enable set, pin follows flag (flag still 1)
      set_cfg(1'b1, 1'b1);
      check(pin_pull_low, 1'b1, "R9 flag drives pin");
      // R6: read clears flag and releases pin
      clear_flag();
      check(alarm_flag, 1'b0, "R6 flag cleared");
      check(pin_pull_low, 1'b0, "R6 pin released");

      // R7: suppression on the flag register address
      rpt_code = 5'b11111;
      ptr_addr = 4'hF;
      tick = 1'b1; step(); tick = 1'b0;
      check(alarm_flag, 1'b0, "R7 suppressed");
      repeat (3) step();
      check(alarm_flag, 1'b0, "R7 still suppressed");
      check(pin_pull_low, 1'b0, "R7 pin released while held");
      ptr_addr = 4'h3;
      step();
      check(alarm_flag, 1'b1, "R7 released after pointer moves");

      // R8: read and new match in the same cycle
      tick = 1'b1; flag_rd = 1'b1;
      step();
      tick = 1'b0; flag_rd = 1'b0;
      check(alarm_flag, 1'b1, "R8 match beats read");
      clear_flag();
      check(alarm_flag, 1'b0, "R8 lone read clears");

      // R8: read in the cycle a pending match is released
      ptr_addr = 4'hF;
      tick = 1'b1; step(); tick = 1'b0;
      check(alarm_flag, 1'b0, "R8 pending held");
      ptr_addr = 4'h0; flag_rd = 1'b1;
      step();
      flag_rd = 1'b0;
      check(alarm_flag, 1'b1, "R8 release beats read");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule